// File: doc/BRIEF.md
# Parallel EPROM Programming Sequencer

This block sits on the host side of a microcontroller's parallel programming interface. It takes one command at a time over a valid/ready port and turns it into a timed pin sequence on the target. The commands are: write a code byte, verify a code byte, write a byte of the encryption array, set one of three lock bits, or read a signature byte. For each command it drives a 13-bit address and an 8-bit data byte, and it applies a mode-select pattern from a parameterised lookup. It then steps the high-voltage enable and the active-low program strobe through a fixed order, with every interval counted in clock cycles.

The high-voltage enable stays low (normal logic level) through the setup interval. It rises for a short lead before the strobe and stays up through the strobe. It stays up for the same lead after the strobe and then drops for a settle interval. Read-type commands never raise it. They sample the returned byte only at the end of the settle interval and report the byte and, for a verify, whether it matched the expected value. The target's clock-enable output comes up straight out of reset, and no command is accepted until a warm-up count has elapsed.

Top module: `eprom_prog_seq`

## Requirements
- R1: `tgt_clk_en` is low during reset and high from the first clock edge after reset release. `cmd_ready` stays low until WARM_CYC (default 16) edges after reset release.
- R2: On the edge that accepts a command, `tgt_addr`, `tgt_data_out` (= `cmd_data`) and `tgt_mode` are loaded. They hold unchanged through the done cycle and after it. Mode patterns per op code: 0 program code = 5'b01110, 1 verify = 5'b00110, 2 encryption = 5'b11110, 6 signature = 5'b00000.
- R3: `tgt_prog_n` is low only while `tgt_vpp_en` is high.
- R4: A programming command (op 0, 2, 3, 4, 5) runs these phases after the accepting edge:
  - SETUP_CYC (10) cycles with vpp low and strobe high;
  - LEAD_CYC (2) cycles with vpp high and strobe high;
  - PULSE_CYC (100) cycles with the strobe low;
  - LEAD_CYC cycles with vpp high and strobe high;
  - SETTLE_CYC (10) cycles with vpp low;
  - one cycle with `rsp_done` high.
- R5: `tgt_data_oe` is high exactly through the setup, lead, pulse, tail and settle cycles of programming commands, and low otherwise.
- R6: A verify (op 1) runs SETUP_CYC cycles and then SETTLE_CYC cycles, all with vpp low and strobe high, then one done cycle. In the done cycle, `rsp_rdata` holds `tgt_data_in` as sampled at the last settle cycle. `rsp_pass` is 1 when that byte equals the command's data and 0 otherwise.
- R7: A signature read (op 6) has the verify timing. It returns the sampled byte in `rsp_rdata` with `rsp_pass` 0.
- R8: An encryption command (op 2) whose address exceeds 0x3F is rejected. The next cycle is a single cycle with `rsp_done` and `rsp_err` high, vpp low and strobe high, and the pins keep their previous values.
- R9: The reserved op code 7 is rejected in the same way as R8.
- R10: `cmd_ready` is low from the accepting edge until the done cycle has ended. A command offered meanwhile is ignored and leaves every output unchanged.
- R11: The lock commands use their own mode patterns, each with its own full pulse sequence: op 3 = 5'b10111, op 4 = 5'b11011, op 5 = 5'b11101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and accepting |
| cmd_op | input | 3 | Command op code |
| cmd_addr | input | 13 | Target address |
| cmd_data | input | 8 | Byte to write, or expected byte for verify |
| tgt_clk_en | output | 1 | Enable for the target's programming clock |
| tgt_addr | output | 13 | Address pins to target |
| tgt_data_out | output | 8 | Data byte to target |
| tgt_data_oe | output | 1 | Drive enable for the data pins |
| tgt_data_in | input | 8 | Byte returned by the target |
| tgt_mode | output | 5 | Mode-select pins |
| tgt_vpp_en | output | 1 | 1 = high-voltage programming level, 0 = logic high |
| tgt_prog_n | output | 1 | Active-low program strobe |
| rsp_done | output | 1 | One-cycle command completion |
| rsp_err | output | 1 | Command rejected (with rsp_done) |
| rsp_pass | output | 1 | Verify matched |
| rsp_rdata | output | 8 | Last byte read back |

## Verification
The assertions check the ordering rules on every cycle:
- the strobe is never low without the high voltage;
- the high voltage never rises together with the strobe and never falls straight out of it;
- sampling happens only at logic level;
- pins are stable during a sequence;
- a rejection never touches the high voltage.

The exact phase lengths need the bench's per-cycle reference model, and so do the sampled byte, the pass/fail result against a modelled target memory, and the fact that commands offered while busy are ignored.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

    typedef enum logic [2:0] {
        OP_PROG_CODE = 3'd0,
        OP_VERIFY    = 3'd1,
        OP_PROG_ENC  = 3'd2,
        OP_LOCK1     = 3'd3,
        OP_LOCK2     = 3'd4,
        OP_LOCK3     = 3'd5,
        OP_READ_SIG  = 3'd6,
        OP_RSVD      = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_WARM,
        ST_IDLE,
        ST_SETUP,
        ST_LEAD,
        ST_PULSE,
        ST_TAIL,
        ST_HOLD,
        ST_FIN
    } st_e;

    localparam int N_OPS  = 8;
    localparam int MODE_W = 5;

    // Packed per op code, op 0 in the low bits.
    localparam logic [N_OPS*MODE_W-1:0] MODE_TABLE_DEF = {
        5'b00000,   // 7 reserved
        5'b00000,   // 6 signature
        5'b11101,   // 5 lock 3
        5'b11011,   // 4 lock 2
        5'b10111,   // 3 lock 1
        5'b11110,   // 2 encryption
        5'b00110,   // 1 verify
        5'b01110    // 0 program code
    };

    function automatic logic is_prog(op_e op);
        return (op == OP_PROG_CODE) || (op == OP_PROG_ENC) ||
               (op == OP_LOCK1) || (op == OP_LOCK2) || (op == OP_LOCK3);
    endfunction

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_mode_lut.sv
module eprom_mode_lut #(
    parameter int MODE_W = 5,
    parameter int N_OPS  = 8,
    parameter logic [N_OPS*MODE_W-1:0] TABLE = '0,
    localparam int OP_W = $clog2(N_OPS)
) (
    input  logic [OP_W-1:0]   op,
    output logic [MODE_W-1:0] mode
);
    logic [MODE_W-1:0] entry [N_OPS];

    for (genvar g = 0; g < N_OPS; g++) begin : g_entry
        assign entry[g] = TABLE[g*MODE_W +: MODE_W];
    end

    assign mode = entry[op];
endmodule

// File: rtl/eprom_phase_timer.sv
module eprom_phase_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int MODE_BITS  = MODE_W,
    parameter logic [N_OPS*MODE_BITS-1:0] MODE_TABLE = MODE_TABLE_DEF,
    parameter int ENC_MAX    = 63,
    parameter int WARM_CYC   = 16,
    parameter int SETUP_CYC  = 10,
    parameter int LEAD_CYC   = 2,
    parameter int PULSE_CYC  = 100,
    parameter int SETTLE_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              tgt_clk_en,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data_out,
    output logic              tgt_data_oe,
    input  logic [DATA_W-1:0] tgt_data_in,
    output logic [MODE_BITS-1:0] tgt_mode,
    output logic              tgt_vpp_en,
    output logic              tgt_prog_n,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic              rsp_pass,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int MAX_CYC = max_int(max_int(max_int(WARM_CYC, SETUP_CYC),
                                     max_int(LEAD_CYC, PULSE_CYC)), SETTLE_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        st_e                 st;
        op_e                 op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   dout;
        logic [DATA_W-1:0]   expv;
        logic [MODE_BITS-1:0] mode;
        logic [DATA_W-1:0]   rval;
        logic                pass;
        logic                err;
        logic                clk_en;
    } regs_t;

    regs_t r_d, r_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic [MODE_BITS-1:0] lut_mode;
    op_e              in_op;
    logic             in_bad;

    assign in_op  = op_e'(cmd_op);
    assign in_bad = (in_op == OP_RSVD) ||
                    ((in_op == OP_PROG_ENC) && (cmd_addr > ADDR_W'(ENC_MAX)));

    eprom_mode_lut #(
        .MODE_W (MODE_BITS),
        .N_OPS  (N_OPS),
        .TABLE  (MODE_TABLE)
    ) u_lut (
        .op   (cmd_op),
        .mode (lut_mode)
    );

    eprom_phase_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (WARM_CYC - 1)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.clk_en = 1'b1;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_WARM: begin
                if (tmr_last) r_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (in_bad) begin
                        r_d.st  = ST_FIN;
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st   = ST_SETUP;
                        r_d.err  = 1'b0;
                        r_d.op   = in_op;
                        r_d.addr = cmd_addr;
                        r_d.dout = cmd_data;
                        r_d.expv = cmd_data;
                        r_d.mode = lut_mode;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(SETUP_CYC - 1);
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_last) begin
                    tmr_load = 1'b1;
                    if (is_prog(r_q.op)) begin
                        r_d.st  = ST_LEAD;
                        tmr_val = CNT_W'(LEAD_CYC - 1);
                    end else begin
                        r_d.st  = ST_HOLD;
                        tmr_val = CNT_W'(SETTLE_CYC - 1);
                    end
                end
            end
            ST_LEAD: begin
                if (tmr_last) begin
                    r_d.st   = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(PULSE_CYC - 1);
                end
            end
            ST_PULSE: begin
                if (tmr_last) begin
                    r_d.st   = ST_TAIL;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(LEAD_CYC - 1);
                end
            end
            ST_TAIL: begin
                if (tmr_last) begin
                    r_d.st   = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SETTLE_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (tmr_last) begin
                    r_d.st = ST_FIN;
                    if (!is_prog(r_q.op)) begin
                        r_d.rval = tgt_data_in;
                        r_d.pass = (r_q.op == OP_VERIFY) && (tgt_data_in == r_q.expv);
                    end
                end
            end
            ST_FIN: begin
                r_d.st  = ST_IDLE;
                r_d.err = 1'b0;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_WARM;
        end else begin
            r_q    <= r_d;
        end
    end

    assign cmd_ready    = (r_q.st == ST_IDLE);
    assign tgt_clk_en   = r_q.clk_en;
    assign tgt_addr     = r_q.addr;
    assign tgt_data_out = r_q.dout;
    assign tgt_mode     = r_q.mode;
    assign tgt_vpp_en   = (r_q.st == ST_LEAD) || (r_q.st == ST_PULSE) || (r_q.st == ST_TAIL);
    assign tgt_prog_n   = (r_q.st != ST_PULSE);
    assign tgt_data_oe  = is_prog(r_q.op) &&
                          (r_q.st inside {ST_SETUP, ST_LEAD, ST_PULSE, ST_TAIL, ST_HOLD});
    assign rsp_done     = (r_q.st == ST_FIN);
    assign rsp_err      = (r_q.st == ST_FIN) && r_q.err;
    assign rsp_pass     = r_q.pass;
    assign rsp_rdata    = r_q.rval;

    // R3: strobe only at programming level
    a_r3_strobe_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_prog_n |-> tgt_vpp_en);

    // R4: high voltage rises ahead of the strobe and falls only after it ends
    a_r4_vpp_leads_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_vpp_en) |-> tgt_prog_n);
    a_r4_vpp_trails_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_vpp_en) |-> $past(tgt_prog_n));

    // R6: readback sampled only at logic level, settled for a cycle
    a_r6_sample_at_logic: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD && tmr_last && !is_prog(r_q.op))
        |-> (!tgt_vpp_en && !$past(tgt_vpp_en)));

    // R2: pins frozen while a sequence runs
    a_r2_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.st) inside {ST_SETUP, ST_LEAD, ST_PULSE, ST_TAIL, ST_HOLD})
        |-> ($stable(tgt_addr) && $stable(tgt_data_out) && $stable(tgt_mode)));

    // R1: no command accepted without the target clock
    a_r1_ready_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> tgt_clk_en);

    // R8: a rejection never raises the high voltage or strobes
    a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!tgt_vpp_en && tgt_prog_n && rsp_done));

    // R10: idle means nothing driven toward the array
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!tgt_vpp_en && !tgt_data_oe && tgt_prog_n));
endmodule

// File: tb/eprom_prog_seq_test.sv
module eprom_prog_seq_test;
    localparam int WARM = 16, SET = 10, LEAD = 2, PUL = 100, SETL = 10;
    localparam logic [4:0] M_CODE = 5'b01110, M_VER = 5'b00110, M_ENC = 5'b11110,
                           M_L1 = 5'b10111, M_L2 = 5'b11011, M_L3 = 5'b11101,
                           M_SIG = 5'b00000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [12:0] cmd_addr = '0;
    logic [7:0] cmd_data = '0;
    logic [7:0] tgt_data_in = 8'hFF;
    logic cmd_ready, tgt_clk_en, tgt_data_oe, tgt_vpp_en, tgt_prog_n;
    logic rsp_done, rsp_err, rsp_pass;
    logic [12:0] tgt_addr;
    logic [7:0] tgt_data_out, rsp_rdata;
    logic [4:0] tgt_mode;

    always #5 clk = ~clk;

    eprom_prog_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .tgt_clk_en(tgt_clk_en), .tgt_addr(tgt_addr), .tgt_data_out(tgt_data_out),
        .tgt_data_oe(tgt_data_oe), .tgt_data_in(tgt_data_in), .tgt_mode(tgt_mode),
        .tgt_vpp_en(tgt_vpp_en), .tgt_prog_n(tgt_prog_n), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_pass(rsp_pass), .rsp_rdata(rsp_rdata)
    );

    int tests = 0, fails = 0;
    bit finished = 0;

    task automatic chk(string tag, string name, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, name, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    bit [7:0] tmem [int];
    function automatic bit [7:0] sig_of(bit [12:0] a);
        return a[7:0] ^ 8'hC3;
    endfunction
    always @(posedge tgt_prog_n)
        if (rst_n && tgt_mode == M_CODE) tmem[int'(tgt_addr)] = tgt_data_out;
    always @(negedge clk) begin
        if (tgt_mode == M_SIG) tgt_data_in <= sig_of(tgt_addr);
        else if (tmem.exists(int'(tgt_addr))) tgt_data_in <= tmem[int'(tgt_addr)];
        else tgt_data_in <= 8'hFF;
    end

    // ---------------- reference model ----------------
    typedef struct {
        bit vpp, pn, oe, done, err, chk_pass, pass;
        bit [4:0] mode;
        bit [12:0] addr;
        bit [7:0] dout, rval;
        string mtag, etag, rtag;
    } exp_t;

    exp_t q[$];
    bit [7:0] mmem [int];
    int edges = 0;
    bit [4:0] l_mode = 0;
    bit [12:0] l_addr = 0;
    bit [7:0] l_dout = 0, l_rval = 0;

    function automatic exp_t base();
        exp_t e;
        e.vpp = 0; e.pn = 1; e.oe = 0; e.done = 0; e.err = 0; e.chk_pass = 0; e.pass = 0;
        e.mode = l_mode; e.addr = l_addr; e.dout = l_dout; e.rval = l_rval;
        e.mtag = "R2"; e.etag = "R8"; e.rtag = "R6";
        return e;
    endfunction

    function automatic void push_n(exp_t e, int n);
        for (int i = 0; i < n; i++) q.push_back(e);
    endfunction

    function automatic bit [4:0] mode_of(bit [2:0] op);
        case (op)
            3'd0: return M_CODE;  3'd1: return M_VER;  3'd2: return M_ENC;
            3'd3: return M_L1;    3'd4: return M_L2;   3'd5: return M_L3;
            default: return M_SIG;
        endcase
    endfunction

    function automatic void accept(bit [2:0] op, bit [12:0] a, bit [7:0] d);
        exp_t e = base();
        bit [7:0] rd;
        if (op == 3'd7 || (op == 3'd2 && a > 13'h3F)) begin
            e.done = 1; e.err = 1; e.etag = (op == 3'd7) ? "R9" : "R8";
            q.push_back(e);
            return;
        end
        e.mode = mode_of(op); e.addr = a; e.dout = d;
        if (op >= 3'd3 && op <= 3'd5) e.mtag = "R11";
        if (op == 3'd1 || op == 3'd6) begin
            push_n(e, SET + SETL);
            rd = (op == 3'd6) ? sig_of(a) : (mmem.exists(int'(a)) ? mmem[int'(a)] : 8'hFF);
            e.done = 1; e.rval = rd; e.chk_pass = 1; e.pass = (op == 3'd1) && (rd == d);
            e.rtag = (op == 3'd6) ? "R7" : "R6";
            q.push_back(e);
        end else begin
            if (op == 3'd0) mmem[int'(a)] = d;
            e.oe = 1;  push_n(e, SET);
            e.vpp = 1; push_n(e, LEAD);
            e.pn = 0;  push_n(e, PUL);
            e.pn = 1;  push_n(e, LEAD);
            e.vpp = 0; push_n(e, SETL);
            e.oe = 0;  e.done = 1; q.push_back(e);
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); edges = 0; l_mode = 0; l_addr = 0; l_dout = 0; l_rval = 0;
        end else begin
            bit rdy;
            exp_t e;
            rdy = (edges >= WARM) && (q.size() == 0);
            if (q.size() > 0) begin
                e = q.pop_front();
                l_mode = e.mode; l_addr = e.addr; l_dout = e.dout; l_rval = e.rval;
            end
            if (rdy && cmd_valid) accept(cmd_op, cmd_addr, cmd_data);
            edges++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            exp_t e;
            e = (q.size() > 0) ? q[0] : base();
            chk("R1", "clk_en", tgt_clk_en, edges >= 1);
            chk((edges >= WARM) ? "R10" : "R1", "ready", cmd_ready,
                (edges >= WARM) && (q.size() == 0));
            chk("R4", "vpp_en", tgt_vpp_en, e.vpp);
            chk("R3", "prog_n", tgt_prog_n, e.pn);
            chk("R5", "data_oe", tgt_data_oe, e.oe);
            chk(e.mtag, "mode", tgt_mode, e.mode);
            chk("R2", "addr", tgt_addr, e.addr);
            chk("R2", "data_out", tgt_data_out, e.dout);
            chk("R4", "done", rsp_done, e.done);
            chk(e.etag, "err", rsp_err, e.err);
            chk(e.rtag, "rdata", rsp_rdata, e.rval);
            if (e.chk_pass) chk(e.rtag, "pass", rsp_pass, e.pass);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(bit [2:0] op, bit [12:0] a, bit [7:0] d);
        bit r;
        @(posedge clk); #1;
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
        do begin
            @(negedge clk); r = cmd_ready;
            @(posedge clk);
        end while (!r);
        #1 cmd_valid = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!cmd_ready);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset clk_en", tgt_clk_en, 0);
        chk("R1", "reset ready", cmd_ready, 0);
        chk("R3", "reset prog_n", tgt_prog_n, 1);
        chk("R4", "reset vpp", tgt_vpp_en, 0);
        @(posedge clk); #1 rst_n = 1;
        wait_idle();
        send(3'd0, 13'h1ABC, 8'h5A); wait_idle();           // R4 program code
        send(3'd1, 13'h1ABC, 8'h5A); wait_idle();           // R6 verify pass
        send(3'd1, 13'h1ABC, 8'h00); wait_idle();           // R6 verify mismatch
        send(3'd1, 13'h0003, 8'hFF); wait_idle();           // R6 erased byte
        send(3'd2, 13'h003F, 8'h11); wait_idle();           // encryption top edge
        send(3'd2, 13'h0040, 8'h22); wait_idle();           // R8 rejected
        send(3'd7, 13'h0001, 8'h33); wait_idle();           // R9 rejected
        send(3'd3, 13'h0000, 8'h00); wait_idle();           // R11 lock 1
        send(3'd4, 13'h0000, 8'h00); wait_idle();           // R11 lock 2
        send(3'd5, 13'h0000, 8'h00); wait_idle();           // R11 lock 3
        send(3'd6, 13'h0030, 8'h00); wait_idle();           // R7 signature
        // R10: command offered while busy is ignored
        send(3'd0, 13'h0000, 8'hA5);
        @(posedge clk); #1;
        cmd_valid = 1; cmd_op = 3'd1; cmd_addr = 13'h1FFF; cmd_data = 8'h77;
        repeat (20) @(posedge clk);
        #1 cmd_valid = 0;
        wait_idle();
        send(3'd1, 13'h0000, 8'hA5); wait_idle();           // R6 after R10 run
        send(3'd0, 13'h1FFF, 8'h3C); wait_idle();           // R2 top address
        send(3'd1, 13'h1FFF, 8'h3C); wait_idle();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule